// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit counter that advances on enable pulses from a selectable clock divider. Software programs a control register, a count register and a compare register. Two event outputs go to an interrupt controller: one for a wrap from the top count to zero, and one for a count that equals the compare value. A single output pin can be toggled, cleared or set on each compare match.

The counter has two count modes. In plain counting it runs upward and wraps. It can also be told to restart from zero whenever it matches the compare value. In the pulse-width mode it runs up to the top value, then back down to zero, and repeats. A write to the count register loads a new value. Counting then continues from that value on the next divider pulse.

Top module: `tmr8_core`

## Requirements
- R1: After reset the count, the control register, the compare register, both event outputs and the pin all read 0.
- R2: With clock select code 000 the count holds its value. It changes only when software writes it.
- R3: Select codes 001 to 111 advance the count once every 1, 8, 32, 64, 128, 256 and 1024 clock cycles. The divider restarts when the code leaves 000, so the first advance comes exactly N cycles after the new code takes effect.
- R4: A written count value reads back on the next cycle. Counting then continues from that value on the next divider pulse.
- R5: In plain counting mode, an advance from 0xFF to 0x00 raises the wrap event for exactly one cycle, in the same cycle that the count reads 0x00.
- R6: The compare event is a one-cycle pulse. It is raised after each advance taken while the count equals the compare register.
- R7: With control bit 3 set outside the pulse-width mode, an advance taken while the count equals the compare value loads 0. The count then repeats every compare+1 advances.
- R8: With control bit 6 set, the count turns down after reaching 0xFF and turns up after reaching 0x00. The wrap event never fires in this mode.
- R9: Control bits 5:4 set the pin action on a compare match: 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R10: Control bits 6:0 read back as written, with the clock select in bits 2:0. Bit 7 always reads 0. The compare register reads back as written.
- R11: A count write in a cycle that also carries a divider pulse takes priority. That pulse causes no advance and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 8 | Count write data |
| cmp_wr | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | 8 | Compare write data |
| ctrl_rdata | output | 8 | Control register readback |
| cnt_rdata | output | 8 | Current count |
| cmp_rdata | output | 8 | Compare register readback |
| ovf_irq | output | 1 | One-cycle wrap event |
| cmp_irq | output | 1 | One-cycle compare-match event |
| cmp_pin | output | 1 | Compare-driven output pin |

## Verification
Every divider tap is run through two full periods plus a stop. This shows that each code gives its own division and that the first pulse comes a full period after the restart. Counts are placed just below 0xFF in both plain and pulse-width modes, which separates a real wrap from a direction turn. A small compare value with clear-on-match shows the shortened period, and walking through all four pin actions shows the difference between hold, toggle, clear and set. A count write that lands on a divider pulse shows that the written value wins over the advance.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [2:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV32   = 3'd3,
    CS_DIV64   = 3'd4,
    CS_DIV128  = 3'd5,
    CS_DIV256  = 3'd6,
    CS_DIV1024 = 3'd7
  } clk_sel_e;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_mode_e;

  // bit 6 pwm, bits 5:4 pin mode, bit 3 clear on match, bits 2:0 select
  typedef struct packed {
    logic      pwm;
    pin_mode_e pin_mode;
    logic      clr_on_match;
    clk_sel_e  sel;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  // log2 of the division ratio for each select code
  function automatic int unsigned tap_log2(input logic [2:0] code);
    case (code)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int unsigned DIV_W = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  output logic     tick
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [7:0]       tap_hit;

  // divider held at zero while stopped, so it restarts on leaving 000
  always_comb begin
    if (sel == CS_STOP) div_d = '0;
    else                div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tap_hit[0] = 1'b0;

  for (genvar c = 1; c < 8; c++) begin : g_tap
    localparam int unsigned      LG   = tap_log2(3'(c));
    localparam logic [DIV_W-1:0] MASK = DIV_W'((64'd1 << LG) - 64'd1);
    assign tap_hit[c] = ((div_q & MASK) == MASK);
  end

  assign tick = tap_hit[sel];

  // R3: divider is back at zero one cycle after a stopped select
  a_r3_divider_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) == CS_STOP) |-> (div_q == '0));

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pwm,
  input  logic         clr_on_match,
  input  logic [W-1:0] cmp_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         cmp_evt,
  output logic         match_now
);

  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         ovf_q, ovf_d;
  logic         mat_q, mat_d;
  logic         at_top, at_bot, at_match;

  assign at_top   = (cnt_q == TOP);
  assign at_bot   = (cnt_q == '0);
  assign at_match = (cnt_q == cmp_val);

  always_comb begin
    cnt_d  = cnt_q;
    down_d = pwm ? down_q : 1'b0;
    ovf_d  = 1'b0;
    mat_d  = 1'b0;
    if (wr_en) begin
      cnt_d = wr_data;
    end else if (tick) begin
      mat_d = at_match;
      if (pwm) begin
        if (!down_q) begin
          if (at_top) begin
            down_d = 1'b1;
            cnt_d  = cnt_q - ONE;
          end else begin
            cnt_d  = cnt_q + ONE;
          end
        end else begin
          if (at_bot) begin
            down_d = 1'b0;
            cnt_d  = cnt_q + ONE;
          end else begin
            cnt_d  = cnt_q - ONE;
          end
        end
      end else begin
        ovf_d = at_top;
        if (clr_on_match && at_match) cnt_d = '0;
        else                          cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      ovf_q  <= 1'b0;
      mat_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      ovf_q  <= ovf_d;
      mat_q  <= mat_d;
    end
  end

  assign cnt       = cnt_q;
  assign ovf_evt   = ovf_q;
  assign cmp_evt   = mat_q;
  assign match_now = mat_d;

  // R5: a wrap event is seen together with a zero count
  a_r5_wrap_lands_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> (cnt == '0));

  // R8: no wrap event while counting up and down
  a_r8_no_wrap_in_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !$past(pwm));

  // R8: the top value turns the count downward
  a_r8_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && pwm && !down_q && at_top) |=> (cnt == TOP - ONE));

  // R6: compare event follows an advance taken at the compare value
  a_r6_event_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> ($past(cnt) == $past(cmp_val)));

  // R7: clear on match loads zero
  a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && !pwm && clr_on_match && at_match) |=> (cnt == '0));

  // R11: a count write wins over the divider pulse
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((cnt == $past(wr_data)) && !ovf_evt && !cmp_evt));

endmodule

// File: rtl/tmr8_pin.sv
module tmr8_pin
  import tmr8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      match_now,
  output logic      pin
);

  logic pin_q, pin_d;

  always_comb begin
    pin_d = pin_q;
    if (match_now) begin
      case (mode)
        PIN_TOGGLE: pin_d = ~pin_q;
        PIN_CLEAR:  pin_d = 1'b0;
        PIN_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R9: hold mode never moves the pin
  a_r9_hold_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PIN_HOLD) |=> $stable(pin));

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [7:0]       ctrl_rdata,
  output logic [CNT_W-1:0] cnt_rdata,
  output logic [CNT_W-1:0] cmp_rdata,
  output logic             ovf_irq,
  output logic             cmp_irq,
  output logic             cmp_pin
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_ns = rst_sync_q[1];

  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             tick;
  logic             match_now;

  always_comb begin
    ctrl_d = ctrl_q;
    cmp_d  = cmp_q;
    if (ctrl_wr) ctrl_d = tmr_ctrl_t'(ctrl_wdata[CTRL_W-1:0]);
    if (cmp_wr)  cmp_d  = cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
    end
  end

  tmr8_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk   (clk),
    .rst_n (rst_ns),
    .sel   (ctrl_q.sel),
    .tick  (tick)
  );

  tmr8_count #(.W(CNT_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_ns),
    .tick         (tick),
    .pwm          (ctrl_q.pwm),
    .clr_on_match (ctrl_q.clr_on_match),
    .cmp_val      (cmp_q),
    .wr_en        (cnt_wr),
    .wr_data      (cnt_wdata),
    .cnt          (cnt_rdata),
    .ovf_evt      (ovf_irq),
    .cmp_evt      (cmp_irq),
    .match_now    (match_now)
  );

  tmr8_pin u_pin (
    .clk       (clk),
    .rst_n     (rst_ns),
    .mode      (ctrl_q.pin_mode),
    .match_now (match_now),
    .pin       (cmp_pin)
  );

  assign ctrl_rdata = {{(8-CTRL_W){1'b0}}, ctrl_q};
  assign cmp_rdata  = cmp_q;

  // R2: a stopped select leaves the count alone
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_ns)
    ((ctrl_q.sel == CS_STOP) && !cnt_wr) |=> $stable(cnt_rdata));

  // R9: the pin only moves together with a compare event
  a_r9_pin_moves_on_match: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(cmp_pin) |-> cmp_irq);

  // R10: reserved control bit reads zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    ctrl_rdata[7] == 1'b0);

endmodule

// File: tb/tb_tmr8_core.sv
module tb_tmr8_core;

  logic       clk;
  logic       rst_n;
  logic       ctrl_wr, cnt_wr, cmp_wr;
  logic [7:0] ctrl_wdata, cnt_wdata, cmp_wdata;
  logic [7:0] ctrl_rdata, cnt_rdata, cmp_rdata;
  logic       ovf_irq, cmp_irq, cmp_pin;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  tmr8_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .cmp_wr     (cmp_wr),
    .cmp_wdata  (cmp_wdata),
    .ctrl_rdata (ctrl_rdata),
    .cnt_rdata  (cnt_rdata),
    .cmp_rdata  (cmp_rdata),
    .ovf_irq    (ovf_irq),
    .cmp_irq    (cmp_irq),
    .cmp_pin    (cmp_pin)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string      req;
    logic [7:0] cnt;
    logic       ovf;
    logic       cme;
    logic       pin;
  } exp_t;

  exp_t sb[$];

  // monitor: one scoreboard entry per clock, compared after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.req != "") begin
          n_checks++;
          if (cnt_rdata !== e.cnt || ovf_irq !== e.ovf || cmp_irq !== e.cme || cmp_pin !== e.pin) begin
            n_fail++;
            $display("FAIL %s: cnt=%h ovf=%b cmp=%b pin=%b expected cnt=%h ovf=%b cmp=%b pin=%b",
                     e.req, cnt_rdata, ovf_irq, cmp_irq, cmp_pin, e.cnt, e.ovf, e.cme, e.pin);
          end
        end
      end
    end
  end

  // driver: set one cycle of inputs and push what the outputs must show after the edge
  task automatic drive(input bit cw, input logic [7:0] cd, input bit nw, input logic [7:0] nd,
                       input bit mw, input logic [7:0] md, input string req,
                       input logic [7:0] ecnt, input logic eovf, input logic ecme, input logic epin);
    exp_t e;
    @(negedge clk);
    ctrl_wr = cw; ctrl_wdata = cd;
    cnt_wr  = nw; cnt_wdata  = nd;
    cmp_wr  = mw; cmp_wdata  = md;
    e.req = req; e.cnt = ecnt; e.ovf = eovf; e.cme = ecme; e.pin = epin;
    sb.push_back(e);
  endtask

  task automatic idle();
    drive(0, 8'h00, 0, 8'h00, 0, 8'h00, "", 8'h00, 0, 0, 0);
  endtask

  task automatic look(input string req, input logic [7:0] c, input logic o, input logic m, input logic p);
    drive(0, 8'h00, 0, 8'h00, 0, 8'h00, req, c, o, m, p);
  endtask

  task automatic set_ctrl(input logic [7:0] v, input string req, input logic [7:0] c,
                          input logic o, input logic m, input logic p);
    drive(1, v, 0, 8'h00, 0, 8'h00, req, c, o, m, p);
  endtask

  task automatic set_cnt(input logic [7:0] v, input string req, input logic p);
    drive(0, 8'h00, 1, v, 0, 8'h00, req, v, 0, 0, p);
  endtask

  task automatic set_cmp(input logic [7:0] v);
    drive(0, 8'h00, 0, 8'h00, 1, v, "", 8'h00, 0, 0, 0);
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3: run one tap for two periods, then stop on the following cycle
  task automatic run_tap(input logic [2:0] code, input int n);
    set_cnt(8'h20, "R4", 0);
    set_ctrl({5'b0, code}, "R3", 8'h20, 0, 0, 0);
    for (int k = 1; k <= 2 * n + 1; k++) begin
      logic [7:0] ev;
      ev = 8'h20 + 8'(k / n);
      if (k == 2 * n + 1) set_ctrl(8'h00, "R3", ev, 0, 0, 0);
      else                look("R3", ev, 0, 0, 0);
    end
    look("R2", 8'h20 + 8'd2 + ((n == 1) ? 8'd1 : 8'd0), 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ctrl_wr = 0; cnt_wr = 0; cmp_wr = 0;
    ctrl_wdata = 0; cnt_wdata = 0; cmp_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R1 reset state
    look("R1", 8'h00, 0, 0, 0);
    chk8("R1", ctrl_rdata, 8'h00);
    chk8("R1", cmp_rdata, 8'h00);

    // R10 control and compare readback, bit 7 dropped
    set_ctrl(8'hF8, "", 8'h00, 0, 0, 0);
    set_cmp(8'h50);
    chk8("R10", ctrl_rdata, 8'h78);
    idle();
    chk8("R10", cmp_rdata, 8'h50);
    set_ctrl(8'h00, "", 8'h00, 0, 0, 0);
    idle();

    // R2 stopped counter holds a written value
    set_cnt(8'h10, "R4", 0);
    for (int k = 0; k < 5; k++) look("R2", 8'h10, 0, 0, 0);

    // R3 every tap, restart after stop
    run_tap(3'd1, 1);
    run_tap(3'd2, 8);
    run_tap(3'd3, 32);
    run_tap(3'd4, 64);
    run_tap(3'd5, 128);
    run_tap(3'd6, 256);
    run_tap(3'd7, 1024);

    // R5 wrap from 0xFF
    set_cnt(8'hFD, "R4", 0);
    set_ctrl(8'h01, "R5", 8'hFD, 0, 0, 0);
    look("R5", 8'hFE, 0, 0, 0);
    look("R5", 8'hFF, 0, 0, 0);
    look("R5", 8'h00, 1, 0, 0);
    look("R5", 8'h01, 0, 0, 0);
    set_ctrl(8'h00, "R5", 8'h02, 0, 0, 0);
    look("R2", 8'h02, 0, 0, 0);

    // R6 compare event
    set_cmp(8'h05);
    set_cnt(8'h03, "R4", 0);
    set_ctrl(8'h01, "R6", 8'h03, 0, 0, 0);
    look("R6", 8'h04, 0, 0, 0);
    look("R6", 8'h05, 0, 0, 0);
    look("R6", 8'h06, 0, 1, 0);
    look("R6", 8'h07, 0, 0, 0);
    set_ctrl(8'h00, "R6", 8'h08, 0, 0, 0);
    idle();

    // R7 clear on match, period compare+1
    set_cmp(8'h03);
    set_cnt(8'h00, "R4", 0);
    set_ctrl(8'h09, "R7", 8'h00, 0, 0, 0);
    for (int k = 1; k <= 8; k++) look("R7", 8'(k % 4), 0, (k % 4) == 0, 0);
    set_ctrl(8'h00, "R7", 8'h01, 0, 0, 0);
    idle();

    // R8 up/down with turns at both ends
    set_cmp(8'h50);
    set_cnt(8'hFD, "R4", 0);
    set_ctrl(8'h41, "R8", 8'hFD, 0, 0, 0);
    look("R8", 8'hFE, 0, 0, 0);
    look("R8", 8'hFF, 0, 0, 0);
    look("R8", 8'hFE, 0, 0, 0);
    look("R8", 8'hFD, 0, 0, 0);
    set_ctrl(8'h40, "R8", 8'hFC, 0, 0, 0);
    set_cnt(8'h01, "R4", 0);
    set_ctrl(8'h41, "R8", 8'h01, 0, 0, 0);
    look("R8", 8'h00, 0, 0, 0);
    look("R8", 8'h01, 0, 0, 0);
    look("R8", 8'h02, 0, 0, 0);
    set_ctrl(8'h00, "R8", 8'h03, 0, 0, 0);
    idle();

    // R9 pin actions: toggle, set, hold, clear
    set_cmp(8'h01);
    set_cnt(8'h00, "R4", 0);
    set_ctrl(8'h19, "R9", 8'h00, 0, 0, 0);
    for (int k = 1; k <= 4; k++) look("R9", 8'(k % 2), 0, (k % 2) == 0, ((k / 2) % 2) == 1);
    set_ctrl(8'h39, "R9", 8'h01, 0, 0, 0);
    look("R9", 8'h00, 0, 1, 1);
    look("R9", 8'h01, 0, 0, 1);
    look("R9", 8'h00, 0, 1, 1);
    set_ctrl(8'h09, "R9", 8'h01, 0, 0, 1);
    look("R9", 8'h00, 0, 1, 1);
    look("R9", 8'h01, 0, 0, 1);
    set_ctrl(8'h29, "R9", 8'h00, 0, 1, 1);
    look("R9", 8'h01, 0, 0, 1);
    look("R9", 8'h00, 0, 1, 0);
    look("R9", 8'h01, 0, 0, 0);
    set_ctrl(8'h00, "R9", 8'h00, 0, 1, 0);
    look("R9", 8'h00, 0, 0, 0);

    // R11 count write on a divider pulse
    set_cmp(8'h50);
    set_ctrl(8'h01, "", 8'h00, 0, 0, 0);
    idle();
    set_cnt(8'h40, "R11", 0);
    look("R11", 8'h41, 0, 0, 0);
    look("R4", 8'h42, 0, 0, 0);
    set_ctrl(8'h00, "R11", 8'h43, 0, 0, 0);
    look("R2", 8'h43, 0, 0, 0);

    repeat (3) idle();
    @(negedge clk);
    finish_run();
  end

endmodule